// File: doc/BRIEF.md
# UART Receive/Transmit Queue with Threshold Flags and Flow Control

This block sits between a UART's serializers and the rest of the chip. It holds two 32-entry first-in first-out queues. The receive queue stores each incoming character together with a 3-bit status tag. The transmit queue stores plain bytes. Both queues have simple push and pop strobes, and the entry at the head of each queue is always visible on its data output.

Around the queues the block derives several flags:
- a receive-ready flag, raised once the receive fill level reaches a programmable threshold;
- a transmitter-ready flag, raised while the transmit fill level is at or below a programmable threshold;
- full and empty flags for each queue;
- a sticky overrun flag, set when a character arrives at a full receive queue and cleared by writing 1.

A clear-to-send output is either driven by a software bit or generated automatically from the receive fill level against a third threshold. In the automatic mode the remote sender is throttled before the receive queue overflows.

Configuration arrives over a small write port: a 2-bit select, an 8-bit data word and a write strobe. An active-low synchronous soft reset empties both queues and clears the overrun flag. The configuration is kept across a soft reset.

Top module: `uart_fifo_flow`

## Requirements
- R1: Each queue returns its entries in push order and holds 32 entries. A receive entry carries an 8-bit character and a 3-bit tag (bit 0 parity error, bit 1 framing error, bit 2 break). The tag comes back unchanged with its character. The head entry is visible on the data outputs while the queue is not empty.
- R2: The level output counts the stored entries. Full is high at 32 entries and empty is high at 0 entries. A push and a pop in the same cycle on a non-empty queue leave the level unchanged, and this applies to a full queue too. A pop on an empty queue is ignored.
- R3: A receive push with no pop while the receive queue is full drops the character, leaves the level and head entry unchanged, and sets the overrun flag. The flag stays set until it is cleared.
- R4: Writing select 3 with data bit 0 = 1 clears the overrun flag. Writing 0 in that bit has no effect. A new overrun in the same cycle as the clear leaves the flag set.
- R5: Select 0 data bits [5:0] set the receive threshold. Values above 32 are stored as 32, and the reset value is 1. Receive-ready is high when the receive level is non-zero and at least the threshold.
- R6: Select 1 data bits [5:0] set the transmit threshold. Values below 2 are stored as 2, values above 32 are stored as 32, and the reset value is 2. Transmitter-ready is high when the transmit level is at or below the threshold.
- R7: Select 2 data bits [5:0] set the clear-to-send threshold (above 32 stored as 32, reset 32). Bit 6 selects automatic mode and bit 7 is the software level; both reset to 0. In automatic mode cts_active is high while the receive level is below the threshold. Otherwise it follows bit 7. cts_active is registered and changes one clock after its inputs change.
- R8: soft_rst_n low at a clock edge empties both queues and clears the overrun flag. A push in that cycle is discarded. The thresholds and the clear-to-send mode are kept.
- R9: After rst_n, both queues are empty with level 0, overrun is 0, transmitter-ready is 1, receive-ready is 0 and cts_active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_n | input | 1 | Synchronous active-low queue and flag reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration select (0 rx thr, 1 tx thr, 2 flow, 3 clear) |
| cfg_wdata | input | 8 | Configuration write data |
| rx_push | input | 1 | Push a received character |
| rx_data_in | input | 8 | Received character |
| rx_tag_in | input | 3 | Status tag of the received character |
| rx_pop | input | 1 | Pop the receive head |
| rx_data_out | output | 8 | Receive head character |
| rx_tag_out | output | 3 | Receive head tag |
| rx_level | output | 6 | Receive fill level |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_ready | output | 1 | Receive level reached threshold |
| rx_overrun | output | 1 | Sticky overrun flag |
| tx_push | input | 1 | Push a byte to send |
| tx_data_in | input | 8 | Byte to send |
| tx_pop | input | 1 | Pop the transmit head |
| tx_data_out | output | 8 | Transmit head byte |
| tx_level | output | 6 | Transmit fill level |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue (buffer) empty |
| tx_ready | output | 1 | Transmit level at or below threshold |
| cts_active | output | 1 | Clear-to-send, high allows the remote to send |

## Verification
Every threshold code from 0 to 63 is written for each of the three thresholds, and the queue is then walked through every level from 0 to 32. This separates a wrong comparison direction, a missing clamp at 32 and a missing floor at 2. In automatic clear-to-send mode the receive queue is both filled and drained at every threshold, so deassertion and reassertion are both seen at the exact level. Distinct arithmetic data and tag patterns on fill and drain expose ordering, tag-lane and overwrite errors, including a dropped overrun character. Simultaneous push and pop are tried on an empty, a partly filled and a full queue, and an overrun is made to coincide with a clear.

// File: rtl/uart_ff_pkg.sv
package uart_ff_pkg;

  // Configuration write selects
  typedef enum logic [1:0] {
    SEL_RX_THR = 2'd0,
    SEL_TX_THR = 2'd1,
    SEL_FLOW   = 2'd2,
    SEL_CLEAR  = 2'd3
  } cfg_sel_e;

  // Lowest usable transmit threshold
  localparam int TX_THR_FLOOR = 2;

endpackage

// File: rtl/ffq_fifo.sv
module ffq_fifo #(
  parameter  int WIDTH = 8,
  parameter  int DEPTH = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [LW-1:0]    level_q, level_d;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (level_q == LW'(DEPTH));
  assign empty = (level_q == '0);
  assign level = level_q;
  assign rdata = mem[rd_ptr_q];

  // A full queue still accepts a push when a pop frees a slot in the same cycle
  assign do_pop  = pop && !empty && !clr;
  assign do_push = push && (!full || do_pop) && !clr;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   level_d = level_q + LW'(1);
        2'b01:   level_d = level_q - LW'(1);
        default: level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  // Storage has no reset; only written entries are ever presented
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH));

  a_r2_pushpop_same_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !clr) |=> $stable(level_q));

  a_r2_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty && !clr) |=> empty);

  a_r3_full_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full && !clr) |=> $stable(level_q));

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/ffq_cfg.sv
module ffq_cfg
  import uart_ff_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int CFG_W = LW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ovr_set,
  output logic [LW-1:0]    rx_thr,
  output logic [LW-1:0]    tx_thr,
  output logic [LW-1:0]    cts_thr,
  output logic             cts_auto,
  output logic             cts_sw,
  output logic             ovr_flag
);

  cfg_sel_e      sel;
  logic [LW-1:0] rx_thr_q, rx_thr_d;
  logic [LW-1:0] tx_thr_q, tx_thr_d;
  logic [LW-1:0] cts_thr_q, cts_thr_d;
  logic          cts_auto_q, cts_auto_d;
  logic          cts_sw_q, cts_sw_d;
  logic          ovr_q, ovr_d;
  logic [LW-1:0] field;
  logic          clear_hit;

  assign sel   = cfg_sel_e'(cfg_sel);
  assign field = cfg_wdata[LW-1:0];

  function automatic logic [LW-1:0] clamp_hi(input logic [LW-1:0] v);
    return (int'(v) > DEPTH) ? LW'(DEPTH) : v;
  endfunction

  function automatic logic [LW-1:0] clamp_tx(input logic [LW-1:0] v);
    return (int'(v) < TX_THR_FLOOR) ? LW'(TX_THR_FLOOR) : clamp_hi(v);
  endfunction

  assign clear_hit = cfg_we && (sel == SEL_CLEAR) && cfg_wdata[0];

  always_comb begin
    rx_thr_d   = rx_thr_q;
    tx_thr_d   = tx_thr_q;
    cts_thr_d  = cts_thr_q;
    cts_auto_d = cts_auto_q;
    cts_sw_d   = cts_sw_q;
    if (cfg_we) begin
      case (sel)
        SEL_RX_THR: rx_thr_d = clamp_hi(field);
        SEL_TX_THR: tx_thr_d = clamp_tx(field);
        SEL_FLOW: begin
          cts_thr_d  = clamp_hi(field);
          cts_auto_d = cfg_wdata[LW];
          cts_sw_d   = cfg_wdata[LW+1];
        end
        default: ;
      endcase
    end
  end

  // Soft clear first, then a new overrun, then a write-1 clear
  always_comb begin
    if (soft_clr)       ovr_d = 1'b0;
    else if (ovr_set)   ovr_d = 1'b1;
    else if (clear_hit) ovr_d = 1'b0;
    else                ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr_q   <= LW'(1);
      tx_thr_q   <= LW'(TX_THR_FLOOR);
      cts_thr_q  <= LW'(DEPTH);
      cts_auto_q <= 1'b0;
      cts_sw_q   <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      rx_thr_q   <= rx_thr_d;
      tx_thr_q   <= tx_thr_d;
      cts_thr_q  <= cts_thr_d;
      cts_auto_q <= cts_auto_d;
      cts_sw_q   <= cts_sw_d;
      ovr_q      <= ovr_d;
    end
  end

  assign rx_thr   = rx_thr_q;
  assign tx_thr   = tx_thr_q;
  assign cts_thr  = cts_thr_q;
  assign cts_auto = cts_auto_q;
  assign cts_sw   = cts_sw_q;
  assign ovr_flag = ovr_q;

  a_r6_tx_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_thr_q >= LW'(TX_THR_FLOOR)) && (tx_thr_q <= LW'(DEPTH)));

  a_r3_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !soft_clr && !clear_hit) |=> ovr_q);

  a_r4_ovr_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_set && !soft_clr) |=> ovr_q);

  a_r4_ovr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_hit && !ovr_set) |=> !ovr_q);

endmodule

// File: rtl/ffq_flow.sv
module ffq_flow #(
  parameter  int DEPTH = 32,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_thr,
  input  logic [LW-1:0] tx_thr,
  input  logic [LW-1:0] cts_thr,
  input  logic          cts_auto,
  input  logic          cts_sw,
  output logic          rx_ready,
  output logic          tx_ready,
  output logic          cts_active
);

  logic cts_q, cts_d;
  logic below_cts;

  assign rx_ready  = (rx_level != '0) && (rx_level >= rx_thr);
  assign tx_ready  = (tx_level <= tx_thr);
  assign below_cts = (rx_level < cts_thr);

  always_comb begin
    cts_d = cts_auto ? below_cts : cts_sw;
  end

  // Registered so the pin toggles cleanly once per level change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_q <= 1'b0;
    else        cts_q <= cts_d;
  end

  assign cts_active = cts_q;

  a_r7_auto_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_auto && (rx_level >= cts_thr)) |=> !cts_active);

  a_r7_auto_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_auto && (rx_level < cts_thr)) |=> cts_active);

  a_r7_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_auto |=> (cts_active == $past(cts_sw)));

endmodule

// File: rtl/uart_fifo_flow.sv
module uart_fifo_flow
  import uart_ff_pkg::*;
#(
  parameter  int DEPTH = 32,
  parameter  int DW    = 8,
  parameter  int TW    = 3,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int CFG_W = LW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             rx_push,
  input  logic [DW-1:0]    rx_data_in,
  input  logic [TW-1:0]    rx_tag_in,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_data_out,
  output logic [TW-1:0]    rx_tag_out,
  output logic [LW-1:0]    rx_level,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_ready,
  output logic             rx_overrun,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_data_in,
  input  logic             tx_pop,
  output logic [DW-1:0]    tx_data_out,
  output logic [LW-1:0]    tx_level,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_ready,
  output logic             cts_active
);

  localparam int RXW = DW + TW;

  logic            soft_clr;
  logic [RXW-1:0]  rx_wword, rx_rword;
  logic            ovr_set;
  logic [LW-1:0]   rx_thr, tx_thr, cts_thr;
  logic            cts_auto, cts_sw;

  assign soft_clr = !soft_rst_n;
  assign rx_wword = {rx_tag_in, rx_data_in};

  ffq_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rx_q (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_clr),
    .push  (rx_push),
    .pop   (rx_pop),
    .wdata (rx_wword),
    .rdata (rx_rword),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  assign rx_data_out = rx_rword[DW-1:0];
  assign rx_tag_out  = rx_rword[RXW-1:DW];

  ffq_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_tx_q (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_clr),
    .push  (tx_push),
    .pop   (tx_pop),
    .wdata (tx_data_in),
    .rdata (tx_data_out),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  // Dropped character: full, no slot freed this cycle
  assign ovr_set = rx_push && rx_full && !rx_pop && !soft_clr;

  ffq_cfg #(.DEPTH(DEPTH)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .ovr_set   (ovr_set),
    .rx_thr    (rx_thr),
    .tx_thr    (tx_thr),
    .cts_thr   (cts_thr),
    .cts_auto  (cts_auto),
    .cts_sw    (cts_sw),
    .ovr_flag  (rx_overrun)
  );

  ffq_flow #(.DEPTH(DEPTH)) u_flow (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .rx_thr     (rx_thr),
    .tx_thr     (tx_thr),
    .cts_thr    (cts_thr),
    .cts_auto   (cts_auto),
    .cts_sw     (cts_sw),
    .rx_ready   (rx_ready),
    .tx_ready   (tx_ready),
    .cts_active (cts_active)
  );

  a_r3_overrun_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> (rx_overrun && rx_full));

endmodule

// File: tb/test_uart_fifo_flow.sv
module test_uart_fifo_flow;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n, soft_rst_n, cfg_we;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic       rx_push, rx_pop, tx_push, tx_pop;
  logic [7:0] rx_data_in, tx_data_in;
  logic [2:0] rx_tag_in;
  logic [7:0] rx_data_out, tx_data_out;
  logic [2:0] rx_tag_out;
  logic [5:0] rx_level, tx_level;
  logic       rx_full, rx_empty, rx_ready, rx_overrun;
  logic       tx_full, tx_empty, tx_ready, cts_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  uart_fifo_flow i_uart_fifo_flow (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_push(rx_push), .rx_data_in(rx_data_in), .rx_tag_in(rx_tag_in),
    .rx_pop(rx_pop), .rx_data_out(rx_data_out), .rx_tag_out(rx_tag_out),
    .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .tx_push(tx_push), .tx_data_in(tx_data_in), .tx_pop(tx_pop),
    .tx_data_out(tx_data_out), .tx_level(tx_level), .tx_full(tx_full),
    .tx_empty(tx_empty), .tx_ready(tx_ready), .cts_active(cts_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int sel, input int val);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic srst();
    soft_rst_n = 1'b0;
    tick();
    soft_rst_n = 1'b1;
  endtask

  task automatic rxpush(input int d, input int t);
    rx_push = 1'b1; rx_data_in = 8'(d); rx_tag_in = 3'(t);
    tick();
    rx_push = 1'b0;
  endtask

  task automatic rxpop();
    rx_pop = 1'b1;
    tick();
    rx_pop = 1'b0;
  endtask

  task automatic txpush(input int d);
    tx_push = 1'b1; tx_data_in = 8'(d);
    tick();
    tx_push = 1'b0;
  endtask

  task automatic txpop();
    tx_pop = 1'b1;
    tick();
    tx_pop = 1'b0;
  endtask

  function automatic int clamp32(input int v);
    return (v > DEPTH) ? DEPTH : v;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_up();
    end
  end

  initial begin : main
    rst_n = 1'b0; soft_rst_n = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
    rx_data_in = '0; rx_tag_in = '0; tx_data_in = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    tick();

    // R9 reset state
    chk(rx_empty == 1 && tx_empty == 1, "R9 empty", int'({rx_empty, tx_empty}), 3);
    chk(rx_level == 0 && tx_level == 0, "R9 level", int'(rx_level) + int'(tx_level), 0);
    chk(rx_overrun == 0, "R9 overrun", int'(rx_overrun), 0);
    chk(tx_ready == 1 && rx_ready == 0, "R9 ready", int'({tx_ready, rx_ready}), 2);
    chk(cts_active == 0, "R9 cts", int'(cts_active), 0);
    rxpush(9, 1);
    chk(rx_ready == 1, "R5 default threshold 1", int'(rx_ready), 1);
    srst();

    // R1 R2 fill receive queue
    for (int i = 0; i < DEPTH; i++) begin
      rxpush((i * 7 + 3) & 255, i % 8);
      chk(int'(rx_level) == i + 1, "R2 rx level fill", int'(rx_level), i + 1);
      chk(rx_full == (i == DEPTH - 1), "R2 rx full", int'(rx_full), int'(i == DEPTH - 1));
      chk(rx_empty == 0, "R2 rx not empty", int'(rx_empty), 0);
    end
    // R3 overrun drop
    rxpush(8'hAA, 7);
    chk(int'(rx_level) == DEPTH, "R3 level unchanged", int'(rx_level), DEPTH);
    chk(rx_overrun == 1, "R3 overrun set", int'(rx_overrun), 1);
    chk(int'(rx_data_out) == 3, "R3 head unchanged", int'(rx_data_out), 3);
    // R1 drain order with tags
    for (int i = 0; i < DEPTH; i++) begin
      chk(int'(rx_data_out) == ((i * 7 + 3) & 255), "R1 rx data order", int'(rx_data_out), (i * 7 + 3) & 255);
      chk(int'(rx_tag_out) == i % 8, "R1 rx tag order", int'(rx_tag_out), i % 8);
      rxpop();
      chk(int'(rx_level) == DEPTH - 1 - i, "R2 rx level drain", int'(rx_level), DEPTH - 1 - i);
    end
    rxpop();
    chk(rx_level == 0 && rx_empty == 1, "R2 pop on empty ignored", int'(rx_level), 0);
    chk(rx_overrun == 1, "R3 overrun sticky", int'(rx_overrun), 1);

    // R4 clear semantics
    cfg(3, 0);
    chk(rx_overrun == 1, "R4 write 0 no effect", int'(rx_overrun), 1);
    cfg(3, 1);
    chk(rx_overrun == 0, "R4 write 1 clears", int'(rx_overrun), 0);
    for (int i = 0; i < DEPTH; i++) rxpush(i, 0);
    rx_push = 1'b1; rx_data_in = 8'h77; cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'd1;
    tick();
    rx_push = 1'b0; cfg_we = 1'b0;
    chk(rx_overrun == 1, "R4 set wins over clear", int'(rx_overrun), 1);
    cfg(3, 1);
    // R2 push and pop while full
    rx_push = 1'b1; rx_pop = 1'b1; rx_data_in = 8'h55;
    tick();
    rx_push = 1'b0; rx_pop = 1'b0;
    chk(int'(rx_level) == DEPTH, "R2 push+pop full level", int'(rx_level), DEPTH);
    chk(rx_overrun == 0, "R2 push+pop full no overrun", int'(rx_overrun), 0);
    chk(int'(rx_data_out) == 1, "R1 head after push+pop", int'(rx_data_out), 1);
    // R2 push and pop partly filled
    rxpop();
    rx_push = 1'b1; rx_pop = 1'b1;
    tick();
    rx_push = 1'b0; rx_pop = 1'b0;
    chk(int'(rx_level) == DEPTH - 1, "R2 push+pop mid level", int'(rx_level), DEPTH - 1);
    // R8 soft reset with push pending
    cfg(3, 0);
    rx_push = 1'b1; tx_push = 1'b1;
    txpush(5);
    rx_push = 1'b1; tx_push = 1'b1; soft_rst_n = 1'b0;
    tick();
    rx_push = 1'b0; tx_push = 1'b0; soft_rst_n = 1'b1;
    chk(rx_level == 0 && tx_level == 0, "R8 soft reset empties", int'(rx_level) + int'(tx_level), 0);
    // R2 push and pop on empty
    rx_push = 1'b1; rx_pop = 1'b1; rx_data_in = 8'h3C;
    tick();
    rx_push = 1'b0; rx_pop = 1'b0;
    chk(rx_level == 1, "R2 push+pop empty", int'(rx_level), 1);
    chk(rx_data_out == 8'h3C, "R1 head after empty push+pop", int'(rx_data_out), 'h3C);
    for (int i = 0; i < DEPTH; i++) rxpush(i, 0);
    chk(rx_overrun == 1, "R3 overrun before soft reset", int'(rx_overrun), 1);
    srst();
    chk(rx_overrun == 0, "R8 soft reset clears overrun", int'(rx_overrun), 0);

    // R5 receive threshold sweep
    for (int t = 0; t < 64; t++) begin
      int e;
      e = clamp32(t);
      cfg(0, t);
      chk(rx_ready == 0, "R5 ready at level 0", int'(rx_ready), 0);
      for (int lvl = 1; lvl <= DEPTH; lvl++) begin
        rxpush(lvl, 0);
        chk(rx_ready == (lvl >= e), "R5 rx ready", int'(rx_ready), int'(lvl >= e));
      end
      srst();
    end
    // R8 configuration kept across soft reset
    cfg(0, 5);
    srst();
    for (int i = 0; i < 4; i++) rxpush(i, 0);
    chk(rx_ready == 0, "R8 threshold kept below", int'(rx_ready), 0);
    rxpush(4, 0);
    chk(rx_ready == 1, "R8 threshold kept at", int'(rx_ready), 1);
    srst();

    // R6 transmit threshold sweep and R1 transmit order
    for (int t = 0; t < 64; t++) begin
      int e;
      e = (t < 2) ? 2 : clamp32(t);
      cfg(1, t);
      chk(tx_ready == 1, "R6 ready at level 0", int'(tx_ready), 1);
      for (int lvl = 1; lvl <= DEPTH; lvl++) begin
        txpush((lvl * 13 + t) & 255);
        chk(tx_ready == (lvl <= e), "R6 tx ready", int'(tx_ready), int'(lvl <= e));
      end
      chk(tx_full == 1 && tx_empty == 0, "R2 tx full", int'({tx_full, tx_empty}), 2);
      for (int lvl = 1; lvl <= DEPTH; lvl++) begin
        chk(int'(tx_data_out) == ((lvl * 13 + t) & 255), "R1 tx order", int'(tx_data_out), (lvl * 13 + t) & 255);
        txpop();
      end
      chk(tx_empty == 1, "R2 tx empty after drain", int'(tx_empty), 1);
    end

    // R7 automatic clear-to-send sweep
    for (int t = 0; t < 64; t++) begin
      int e;
      e = clamp32(t);
      cfg(2, 64 + t);
      tick();
      chk(cts_active == (0 < e), "R7 cts at level 0", int'(cts_active), int'(0 < e));
      for (int lvl = 1; lvl <= DEPTH; lvl++) begin
        rxpush(lvl, 0);
        tick();
        chk(cts_active == (lvl < e), "R7 cts filling", int'(cts_active), int'(lvl < e));
      end
      for (int lvl = DEPTH - 1; lvl >= 0; lvl--) begin
        rxpop();
        tick();
        chk(cts_active == (lvl < e), "R7 cts draining", int'(cts_active), int'(lvl < e));
      end
    end
    // R7 manual mode ignores level
    for (int i = 0; i < DEPTH; i++) rxpush(i, 0);
    cfg(2, 128);
    tick();
    chk(cts_active == 1, "R7 manual high", int'(cts_active), 1);
    cfg(2, 0);
    tick();
    chk(cts_active == 0, "R7 manual low", int'(cts_active), 0);
    srst();

    done = 1;
    finish_up();
  end

endmodule